// File: doc/BRIEF.md
# Linked-List Buffer Free Pool

This block keeps track of which fixed-size packet buffers in a shared packet memory are free. Free buffer IDs are chained into a singly linked list held in an internal link table. A client that needs a buffer raises an allocate request and is given the ID at the head of the list in the same cycle. A client that is done with a buffer returns its ID with a release request, and that ID is appended behind the current tail. Buffers therefore come back into use in the order they were freed.

After reset the block builds the initial chain by itself, one table entry per clock. It then raises an initialization-done flag and starts serving requests. Head, tail and free count are visible as status values. There is also an empty flag, and an alarm that goes high when the free count falls to a programmable threshold. The alarm is meant to drive flow control and a buffer-alarm indicator elsewhere in the chip.

Top module: `bfp_free_pool`

## Requirements
- R1: After reset is released, the chain is built in exactly NUM_BUFS clock cycles. `init_done` goes high on the NUM_BUFS-th rising edge and stays high until the next reset. While it is low, `count_o` reads 0 and `empty_o` and `alarm` read 0.
- R2: When initialization completes, `head_o` = 0, `tail_o` = NUM_BUFS-1 and `count_o` = NUM_BUFS.
- R3: Starting from a freshly built pool, successive grants return IDs 0, 1, 2, ... NUM_BUFS-1 in ascending order.
- R4: `alloc_gnt` is high in the same cycle as `alloc_req` when `init_done` is 1 and `count_o` is not 0. `alloc_id` then equals `head_o`. Without a simultaneous release, `count_o` is one lower after the clock edge.
- R5: An accepted release sets `tail_o` to `rel_id` after the edge and raises `count_o` by one (without a simultaneous grant). Released IDs are handed out again in the order they were released, behind any IDs already free.
- R6: After initialization, `empty_o` is 1 exactly when `count_o` is 0. An allocate request while `count_o` is 0 gets no grant and changes nothing.
- R7: When a grant and a release occur in the same cycle, both are served and `count_o` is unchanged. If `count_o` was 1, the released ID is the next one granted. If `count_o` was 0, only the release is served and `count_o` becomes 1.
- R8: `alarm` is 1 exactly when `init_done` is 1 and `count_o` <= `alarm_thresh`.
- R9: An ID is never granted a second time unless it has been released after its previous grant.
- R10: Allocate and release requests made while `init_done` is 0 are ignored: no grant is given, and the pool state after initialization is as in R2.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous reset, active low |
| alloc_req | input | 1 | Request one free buffer ID this cycle |
| alloc_gnt | output | 1 | Request served this cycle; `alloc_id` is valid |
| alloc_id | output | ID_W | Granted buffer ID (current head) |
| rel_req | input | 1 | Return the ID on `rel_id` to the pool |
| rel_id | input | ID_W | Buffer ID being returned |
| alarm_thresh | input | ID_W | Free-count level at or below which `alarm` is raised |
| head_o | output | ID_W | ID at the front of the free list |
| tail_o | output | ID_W | ID at the back of the free list |
| count_o | output | ID_W | Number of free buffers |
| empty_o | output | 1 | Free count is zero |
| init_done | output | 1 | Free list has been built |
| alarm | output | 1 | Free count at or below threshold |

## Verification
The assertions follow the bookkeeping on every cycle:
- no grant before initialization or on an empty pool;
- the count moves by exactly one per lone grant or release and holds when both occur together;
- the tail follows each release;
- the empty and alarm flags agree with the count;
- initialization-done never drops.

Other behaviours involve the contents of the link table, so only the bench's scenarios can show them: the ascending initial order, first-freed-first-reused ordering, the hand-over of a released ID through a pool of one, and that no ID is ever issued twice. The bench does this with a queue model over directed corner cases and a long mixed sequence on a ten-buffer pool.

// File: rtl/bfp_pkg.sv
// Package: shared types for the buffer free pool.
// Assumes nothing beyond IEEE 1800-2017 enum support.
package bfp_pkg;

    // Phase of the pool: building the chain, or serving requests.
    typedef enum logic [0:0] {
        PH_BUILD = 1'b0,
        PH_RUN   = 1'b1
    } pool_phase_t;

endpackage

// File: rtl/bfp_init_seq.sv
// Module: bfp_init_seq
// Walks an index from 0 to NUM_BUFS-1 after reset, one step per clock,
// so the link table can be loaded with the initial chain. Raises `last`
// in the cycle that writes the final entry, then stays in the run phase.
// Assumes NUM_BUFS >= 2 and NUM_BUFS < 2**ID_W.
module bfp_init_seq
    import bfp_pkg::*;
#(
    parameter int NUM_BUFS = 2730,
    parameter int ID_W     = 12
) (
    input  logic            clk,
    input  logic            rst_n,
    output logic            building,
    output logic            last,
    output logic            running,
    output logic [ID_W-1:0] idx
);
    localparam logic [ID_W-1:0] LAST_IDX = ID_W'(NUM_BUFS - 1);

    pool_phase_t phase;

    // Advance the build index and switch to run after the last entry.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            phase <= PH_BUILD;
            idx   <= '0;
        end else if (phase == PH_BUILD) begin
            if (idx == LAST_IDX) begin
                phase <= PH_RUN;
            end else begin
                idx <= idx + 1'b1;
            end
        end
    end

    // Decode the phase for the neighbours.
    always_comb begin
        building = (phase == PH_BUILD);
        running  = (phase == PH_RUN);
        last     = building && (idx == LAST_IDX);
    end
endmodule

// File: rtl/bfp_link_table.sv
// Module: bfp_link_table
// Holds the next-pointer of each buffer ID: one synchronous write port,
// one asynchronous read port. Contents are not reset; the init sequencer
// fills every entry before it is read.
// Assumes $clog2(NUM_BUFS) <= ID_W.
module bfp_link_table #(
    parameter int NUM_BUFS = 2730,
    parameter int ID_W     = 12
) (
    input  logic            clk,
    input  logic            we,
    input  logic [ID_W-1:0] waddr,
    input  logic [ID_W-1:0] wdata,
    input  logic [ID_W-1:0] raddr,
    output logic [ID_W-1:0] rdata
);
    localparam int AW = $clog2(NUM_BUFS);

    logic [ID_W-1:0] links [NUM_BUFS];

    // Store one next-pointer per clock when enabled.
    always_ff @(posedge clk) begin
        if (we) begin
            links[waddr[AW-1:0]] <= wdata;
        end
    end

    // Read the successor of the requested ID.
    always_comb begin
        rdata = links[raddr[AW-1:0]];
    end
endmodule

// File: rtl/bfp_ptr_ctrl.sv
// Module: bfp_ptr_ctrl
// Owns head, tail and free count. Pops the head on a grant and appends at
// the tail on a release, with the one-entry and empty cases forwarded so
// a simultaneous grant and release stay consistent.
// Assumes clients never release an ID that is already free.
module bfp_ptr_ctrl #(
    parameter int NUM_BUFS = 2730,
    parameter int ID_W     = 12
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            load,
    input  logic            running,
    input  logic            alloc_req,
    input  logic            rel_req,
    input  logic [ID_W-1:0] rel_id,
    input  logic [ID_W-1:0] next_of_head,
    output logic            gnt,
    output logic            rel_wr,
    output logic [ID_W-1:0] head,
    output logic [ID_W-1:0] tail,
    output logic [ID_W-1:0] count
);
    localparam logic [ID_W-1:0] FULL_CNT = ID_W'(NUM_BUFS);
    localparam logic [ID_W-1:0] LAST_ID  = ID_W'(NUM_BUFS - 1);

    logic rel_ok;
    logic is_empty;
    logic is_single;

    // Decide which requests are served this cycle.
    always_comb begin
        is_empty  = (count == '0);
        is_single = (count == ID_W'(1));
        gnt       = running && alloc_req && !is_empty;
        rel_ok    = running && rel_req;
        rel_wr    = rel_ok && !is_empty;
    end

    // Update head, tail and count from the load pulse or served requests.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            head  <= '0;
            tail  <= '0;
            count <= '0;
        end else if (load) begin
            head  <= '0;
            tail  <= LAST_ID;
            count <= FULL_CNT;
        end else begin
            if (gnt) begin
                head <= (rel_ok && is_single) ? rel_id : next_of_head;
            end else if (rel_ok && is_empty) begin
                head <= rel_id;
            end
            if (rel_ok) begin
                tail <= rel_id;
            end
            if (gnt && !rel_ok) begin
                count <= count - 1'b1;
            end else if (rel_ok && !gnt) begin
                count <= count + 1'b1;
            end
        end
    end
endmodule

// File: rtl/bfp_free_pool.sv
// Module: bfp_free_pool (top)
// Free list of packet-buffer IDs kept as a linked chain. Builds the chain
// after reset, grants the head on request, appends released IDs at the
// tail, and reports head, tail, count, empty and a threshold alarm.
// Assumes NUM_BUFS >= 2, NUM_BUFS < 2**ID_W, and well-behaved clients.
module bfp_free_pool #(
    parameter int NUM_BUFS = 2730,
    parameter int ID_W     = 12
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            alloc_req,
    output logic            alloc_gnt,
    output logic [ID_W-1:0] alloc_id,
    input  logic            rel_req,
    input  logic [ID_W-1:0] rel_id,
    input  logic [ID_W-1:0] alarm_thresh,
    output logic [ID_W-1:0] head_o,
    output logic [ID_W-1:0] tail_o,
    output logic [ID_W-1:0] count_o,
    output logic            empty_o,
    output logic            init_done,
    output logic            alarm
);
    logic            building;
    logic            last;
    logic            running;
    logic [ID_W-1:0] idx;
    logic            rel_wr;
    logic [ID_W-1:0] next_of_head;
    logic            we;
    logic [ID_W-1:0] waddr;
    logic [ID_W-1:0] wdata;

    bfp_init_seq #(.NUM_BUFS(NUM_BUFS), .ID_W(ID_W)) u_init (
        .clk      (clk),
        .rst_n    (rst_n),
        .building (building),
        .last     (last),
        .running  (running),
        .idx      (idx)
    );

    // Share the single table write port between building and releasing.
    always_comb begin
        if (building) begin
            we    = 1'b1;
            waddr = idx;
            wdata = idx + 1'b1;
        end else begin
            we    = rel_wr;
            waddr = tail_o;
            wdata = rel_id;
        end
    end

    bfp_link_table #(.NUM_BUFS(NUM_BUFS), .ID_W(ID_W)) u_links (
        .clk   (clk),
        .we    (we),
        .waddr (waddr),
        .wdata (wdata),
        .raddr (head_o),
        .rdata (next_of_head)
    );

    bfp_ptr_ctrl #(.NUM_BUFS(NUM_BUFS), .ID_W(ID_W)) u_ptr (
        .clk          (clk),
        .rst_n        (rst_n),
        .load         (last),
        .running      (running),
        .alloc_req    (alloc_req),
        .rel_req      (rel_req),
        .rel_id       (rel_id),
        .next_of_head (next_of_head),
        .gnt          (alloc_gnt),
        .rel_wr       (rel_wr),
        .head         (head_o),
        .tail         (tail_o),
        .count        (count_o)
    );

    // Status flags derived from the free count.
    always_comb begin
        init_done = running;
        alloc_id  = head_o;
        empty_o   = running && (count_o == '0);
        alarm     = running && (count_o <= alarm_thresh);
    end
endmodule

// File: rtl/bfp_free_pool_chk.sv
// Module: bfp_free_pool_chk
// Cycle-level checks on the free pool's ports, bound into every instance.
// Assumes clients release only IDs they hold.
module bfp_free_pool_chk #(
    parameter int ID_W = 12
) (
    input logic            clk,
    input logic            rst_n,
    input logic            alloc_req,
    input logic            alloc_gnt,
    input logic [ID_W-1:0] alloc_id,
    input logic            rel_req,
    input logic [ID_W-1:0] rel_id,
    input logic [ID_W-1:0] alarm_thresh,
    input logic [ID_W-1:0] head_o,
    input logic [ID_W-1:0] tail_o,
    input logic [ID_W-1:0] count_o,
    input logic            empty_o,
    input logic            init_done,
    input logic            alarm
);
    AST_DONE_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
        init_done |=> init_done); // R1
    AST_NO_GNT_EARLY: assert property (@(posedge clk) disable iff (!rst_n)
        !init_done |-> !alloc_gnt); // R10
    AST_GNT_NEEDS_STOCK: assert property (@(posedge clk) disable iff (!rst_n)
        alloc_gnt |-> (count_o != '0) && alloc_req); // R6
    AST_GNT_IS_HEAD: assert property (@(posedge clk) disable iff (!rst_n)
        alloc_gnt |-> (alloc_id == head_o)); // R4
    AST_CNT_DOWN: assert property (@(posedge clk) disable iff (!rst_n)
        (alloc_gnt && !rel_req) |=> (count_o == ID_W'($past(count_o) - 1'b1))); // R4
    AST_CNT_UP: assert property (@(posedge clk) disable iff (!rst_n)
        (init_done && rel_req && !alloc_gnt) |=> (count_o == ID_W'($past(count_o) + 1'b1))); // R5
    AST_TAIL_FOLLOWS: assert property (@(posedge clk) disable iff (!rst_n)
        (init_done && rel_req) |=> (tail_o == $past(rel_id))); // R5
    AST_CNT_BALANCED: assert property (@(posedge clk) disable iff (!rst_n)
        (alloc_gnt && rel_req) |=> $stable(count_o)); // R7
    AST_EMPTY_FLAG: assert property (@(posedge clk) disable iff (!rst_n)
        init_done |-> (empty_o == (count_o == '0))); // R6
    AST_ALARM_LEVEL: assert property (@(posedge clk) disable iff (!rst_n)
        alarm |-> (init_done && count_o <= alarm_thresh)); // R8
endmodule

bind bfp_free_pool bfp_free_pool_chk #(.ID_W(ID_W)) u_chk (.*);

// File: tb/bfp_free_pool_bench.sv
// Bench: bfp_free_pool_bench
// Queue model of the free list on a ten-buffer pool; directed corners
// followed by a long mixed sequence.
module bfp_free_pool_bench;
    localparam int NB = 10;
    localparam int IW = 4;
    localparam time CLK_PERIOD = 10ns;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          alloc_req = 1'b0;
    logic          alloc_gnt;
    logic [IW-1:0] alloc_id;
    logic          rel_req = 1'b0;
    logic [IW-1:0] rel_id = '0;
    logic [IW-1:0] alarm_thresh = '0;
    logic [IW-1:0] head_o, tail_o, count_o;
    logic          empty_o, init_done, alarm;

    int n_chk = 0;
    int n_fail = 0;
    int cyc = 0;
    bit done_flag = 1'b0;

    int q[$];          // model free list, front = next grant
    bit held[NB];      // IDs currently owned by clients
    int owned[$];      // list of owned IDs for release choice

    bfp_free_pool #(.NUM_BUFS(NB), .ID_W(IW)) u_bfp_free_pool (.*);

    always #(CLK_PERIOD/2) clk = ~clk;

    task automatic chk(input bit ok, input string tag, input int act, input int exp);
        n_chk++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
        end
    endtask

    task automatic summary();
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    endtask

    // Watchdog: a hung run counts as a failed check.
    always @(posedge clk) begin
        cyc++;
        if (cyc > 60000 && !done_flag) begin
            n_fail++;
            $display("FAIL watchdog actual=%0d expected=%0d", cyc, 60000);
            summary();
            $finish;
        end
    end

    // One cycle of stimulus, entered and left at a falling edge.
    task automatic op(input bit a, input bit r, input int rid, output bit g, output int gid);
        bit exp_g;
        int exp_id;
        alloc_req = a;
        rel_req   = r;
        rel_id    = IW'(rid);
        #1;
        exp_g  = a && (q.size() > 0);
        exp_id = exp_g ? q[0] : 0;
        g   = alloc_gnt;
        gid = int'(alloc_id);
        chk(g == exp_g, "R4/R6 grant", int'(g), int'(exp_g));
        if (exp_g) begin
            chk(gid == exp_id, "R4 grant id", gid, exp_id);
            chk(!held[gid], "R9 id already held", int'(held[gid]), 0);
        end
        // model update: grant decided on pre-state, then pop, then append
        if (exp_g) begin
            void'(q.pop_front());
            held[exp_id] = 1'b1;
            owned.push_back(exp_id);
        end
        if (r) begin
            q.push_back(rid);
            held[rid] = 1'b0;
        end
        @(posedge clk);
        @(negedge clk);
        alloc_req = 1'b0;
        rel_req   = 1'b0;
        chk(int'(count_o) == q.size(), "R4/R5 count", int'(count_o), q.size());
        chk(empty_o == (q.size() == 0), "R6 empty", int'(empty_o), int'(q.size() == 0));
        chk(alarm == (q.size() <= int'(alarm_thresh)), "R8 alarm", int'(alarm),
            int'(q.size() <= int'(alarm_thresh)));
        if (r) chk(int'(tail_o) == rid, "R5 tail", int'(tail_o), rid);
        if (q.size() > 0) chk(int'(head_o) == q[0], "R5 head order", int'(head_o), q[0]);
    endtask

    task automatic release_owned(input int which);
        bit g;
        int gid;
        int id;
        id = owned[which];
        owned.delete(which);
        op(1'b0, 1'b1, id, g, gid);
    endtask

    initial begin
        bit g;
        int gid;
        int id;
        repeat (3) @(negedge clk);
        chk(init_done == 1'b0, "R1 reset done", int'(init_done), 0);
        chk(count_o == '0, "R1 reset count", int'(count_o), 0);
        // Release reset with requests pending: they must be ignored (R10).
        alloc_req = 1'b1;
        rel_req   = 1'b1;
        rel_id    = IW'(3);
        alarm_thresh = IW'(NB);
        rst_n = 1'b1;
        for (int k = 1; k <= NB; k++) begin
            #1;
            if (k < NB) begin
                chk(alloc_gnt == 1'b0, "R10 no grant during build", int'(alloc_gnt), 0);
                chk(empty_o == 1'b0 && alarm == 1'b0, "R1 flags low during build",
                    int'({empty_o, alarm}), 0);
            end
            @(posedge clk);
            @(negedge clk);
            chk(init_done == (k == NB), "R1 build length", int'(init_done), int'(k == NB));
        end
        alloc_req = 1'b0;
        rel_req   = 1'b0;
        chk(int'(head_o) == 0, "R2 head", int'(head_o), 0);
        chk(int'(tail_o) == NB - 1, "R2/R10 tail", int'(tail_o), NB - 1);
        chk(int'(count_o) == NB, "R2/R10 count", int'(count_o), NB);
        for (int i = 0; i < NB; i++) q.push_back(i);

        // Drain: ascending order (R3), with the alarm threshold at 3.
        alarm_thresh = IW'(3);
        for (int i = 0; i < NB; i++) begin
            op(1'b1, 1'b0, 0, g, gid);
            chk(g && gid == i, "R3 ascending", gid, i);
        end
        op(1'b1, 1'b0, 0, g, gid);
        chk(!g, "R6 no grant when empty", int'(g), 0);

        // Release 7, 2, 5 and expect them back in that order (R5).
        foreach (owned[j]) if (owned[j] == 7) begin release_owned(j); break; end
        foreach (owned[j]) if (owned[j] == 2) begin release_owned(j); break; end
        foreach (owned[j]) if (owned[j] == 5) begin release_owned(j); break; end
        op(1'b1, 1'b0, 0, g, gid); chk(gid == 7, "R5 fifo order", gid, 7);
        op(1'b1, 1'b0, 0, g, gid); chk(gid == 2, "R5 fifo order", gid, 2);
        op(1'b1, 1'b0, 0, g, gid); chk(gid == 5, "R5 fifo order", gid, 5);

        // Empty pool, grant and release together: only the release (R7).
        owned.delete(owned.size() - 1);
        op(1'b1, 1'b1, 5, g, gid);
        chk(!g && count_o == IW'(1), "R7 empty both", int'(count_o), 1);
        // Pool of one, both together: released ID comes next (R7).
        foreach (owned[j]) if (owned[j] == 4) begin owned.delete(j); break; end
        op(1'b1, 1'b1, 4, g, gid);
        chk(g && gid == 5 && count_o == IW'(1), "R7 single both", gid, 5);
        op(1'b1, 1'b0, 0, g, gid);
        chk(gid == 4, "R7 forwarded id", gid, 4);

        // Long mixed sequence with a sweeping threshold (R8, R9).
        for (int n = 0; n < 4000; n++) begin
            int sel;
            bit a, r;
            alarm_thresh = IW'(n % (NB + 2));
            sel = $urandom_range(0, 3);
            a = (sel != 1);
            r = (sel != 0) && (owned.size() > 0);
            id = 0;
            if (r) begin
                int j;
                j = $urandom_range(0, owned.size() - 1);
                id = owned[j];
                owned.delete(j);
            end
            op(a, r, id, g, gid);
        end

        done_flag = 1'b1;
        summary();
        $finish;
    end
endmodule